// File: doc/BRIEF.md
# Write Leveling Edge Searcher

This block finds, for each of eight byte lanes, the strobe delay at which a sampled feedback bit turns from low to high. It does not hold the delay codes. An external delay stepper owns them, starts from safe initial values and moves selected lanes one step up or down on request. The feedback bits come from an 8-bit sample source that the block triggers one sample at a time.

The search runs as a sequence of sampling rounds that all lanes share. A round collects five samples and keeps, for each lane, a count of how many samples were high. The search has two passes:
- The down pass steps every unfinished lane down until its count is zero.
- The up pass starts with every lane unfinished again and steps lanes up until their count is five.

Lanes finish on their own. A finished lane stays where it is for the rest of the pass. After each step the block waits a fixed settle time before the next round. A step error from the stepper ends the search with a failure status. When the search succeeds, the codes left in the stepper are the result.

The controller is one state machine:
- IDLE waits for `start`, clears the status and goes to SAMPLE_REQ in the down pass.
- SAMPLE_REQ raises `smp_req` for one cycle and goes to SAMPLE_WAIT.
- SAMPLE_WAIT waits for `smp_vld`. After the fifth sample it goes to JUDGE, otherwise back to SAMPLE_REQ.
- JUDGE decides what happens next:
  - If any lane still needs a step, it goes to STEP.
  - If every lane is finished in the down pass, it switches to the up pass and goes to SAMPLE_REQ.
  - If every lane is finished in the up pass, it sets `done` and goes to IDLE.
- STEP holds the request until `step_ack`. It then goes to IDLE with `fail` set if `step_err` is high, or to SETTLE if not.
- SETTLE waits SETTLE_CYC cycles and then goes to SAMPLE_REQ.

Top module: `wl_edge_search`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `fail`, `smp_req` and `step_req` are all low.
- R2: A sampling round issues exactly SAMPLES (5) one-cycle sample requests. A new request comes only after the previous sample has been returned with `smp_vld`.
- R3: Each lane's count is the number of high bits in that lane's position of `smp_bits` over the round, capped at SAMPLES. A partial count (1 to 4) is neither the down-pass goal nor the up-pass goal.
- R4: In the down pass (`step_up` = 0), unfinished lanes with a count above zero are requested to step down. Lanes with a count of zero are marked finished.
- R5: The up pass begins with every lane unfinished. Unfinished lanes with a count below SAMPLES are requested to step up (`step_up` = 1). Lanes with a count of exactly SAMPLES are marked finished.
- R6: A finished lane is never set in `step_lanes` while `step_req` is high, and a step request is never empty.
- R7: A pass ends once every lane is finished. The end of the down pass starts a new up-pass round with no step. The end of the up pass drops `busy` and raises `done`, leaving the stepper codes at the found edges.
- R8: If a step request is answered with `step_err` high, the search stops at once. `busy` drops and `fail` rises, `done` stays low, and no further requests are issued.
- R9: After the step acknowledge cycle, exactly SETTLE_CYC cycles pass with `smp_req` low before the next sample request.
- R10: `start` has no effect while `busy` is high.
- R11: `step_req`, `step_lanes` and `step_up` stay stable until `step_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| smp_req | output | 1 | One-cycle request for one feedback sample |
| smp_vld | input | 1 | Sample returned on smp_bits this cycle |
| smp_bits | input | LANES | Feedback bit per lane |
| step_req | output | 1 | Step request, held until step_ack |
| step_up | output | 1 | Step direction: 1 up, 0 down |
| step_lanes | output | LANES | Lanes to move by one step |
| step_ack | input | 1 | Stepper has handled the request |
| step_err | input | 1 | With step_ack: a lane was already at its limit |
| busy | output | 1 | Search in progress |
| done | output | 1 | Last search succeeded |
| fail | output | 1 | Last search ended on a step error |

## Verification
The stepper and sample source are modelled in the bench. Each lane has a hard edge code and an optional jitter band below it, in which only odd-numbered samples read high.

Four kinds of run are used:
- A mixed run, with lanes that start above their edge, inside a jitter band, exactly at the edge or below it. It tells apart lanes with partial counts from lanes at the goal, and down-pass decisions from up-pass decisions. A stray `start` is pulsed during this run.
- A run with every lane already below its edge. Here the down pass ends after one round with no step.
- A run with a lane whose edge sits at code zero, so a down step fails.
- A run with a lane whose edge lies above the top code, so an up step fails.

For every run the bench predicts each step mask and direction, the settle gap, and the final codes or failure.

// File: rtl/wl_edge_pkg.sv
package wl_edge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE_REQ,
        ST_SAMPLE_WAIT,
        ST_JUDGE,
        ST_STEP,
        ST_SETTLE
    } wl_state_e;

    typedef enum logic {
        PASS_DOWN = 1'b0,
        PASS_UP   = 1'b1
    } wl_pass_e;

endpackage

// File: rtl/wl_lane_tally.sv
module wl_lane_tally
    import wl_edge_pkg::*;
#(
    parameter int SAMPLES = 5,
    parameter int CW      = $clog2(SAMPLES + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     hit_en,
    input  logic     bit_i,
    input  logic     done_i,
    input  wl_pass_e pass_i,
    output logic     want_step,
    output logic     reach_goal
);

    localparam logic [CW-1:0] FULL = CW'(SAMPLES);

    logic [CW-1:0] cnt;
    logic          at_goal;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (hit_en && bit_i && cnt != FULL)
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        if (pass_i == PASS_DOWN)
            at_goal = (cnt == '0);
        else
            at_goal = (cnt == FULL);
        want_step  = !done_i && !at_goal;
        reach_goal = !done_i && at_goal;
    end

    // R3: the count never exceeds the number of samples per round
    a_r3_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);

    // R3: a cleared count starts the next round from zero
    a_r3_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);

endmodule

// File: rtl/wl_settle_timer.sv
module wl_settle_timer #(
    parameter int SETTLE_CYC = 4,
    parameter int TW         = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam logic [TW-1:0] LAST = TW'(SETTLE_CYC - 1);

    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr <= '0;
        else if (!run || expired)
            tmr <= '0;
        else
            tmr <= tmr + 1'b1;
    end

    assign expired = run && (tmr == LAST);

    // R9: the timer never runs past its last count
    a_r9_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tmr <= LAST);

endmodule

// File: rtl/wl_edge_search.sv
module wl_edge_search
    import wl_edge_pkg::*;
#(
    parameter int LANES      = 8,
    parameter int SAMPLES    = 5,
    parameter int SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             smp_req,
    input  logic             smp_vld,
    input  logic [LANES-1:0] smp_bits,
    output logic             step_req,
    output logic             step_up,
    output logic [LANES-1:0] step_lanes,
    input  logic             step_ack,
    input  logic             step_err,
    output logic             busy,
    output logic             done,
    output logic             fail
);

    localparam int CW = $clog2(SAMPLES + 1);
    localparam int SW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
    localparam logic [SW-1:0] LAST_SMP = SW'(SAMPLES - 1);

    wl_state_e        state_q, state_d;
    wl_pass_e         pass_q;
    logic [LANES-1:0] lane_done_q;
    logic [LANES-1:0] step_mask_q;
    logic [SW-1:0]    idx_q;
    logic             done_q, fail_q;

    logic [LANES-1:0] want_step, reach_goal;
    logic             tally_clr, tally_hit, settle_done;

    assign tally_clr = (state_q == ST_IDLE) || (state_q == ST_JUDGE);
    assign tally_hit = (state_q == ST_SAMPLE_WAIT) && smp_vld;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wl_lane_tally #(.SAMPLES(SAMPLES), .CW(CW)) u_tally (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (tally_clr),
            .hit_en     (tally_hit),
            .bit_i      (smp_bits[g]),
            .done_i     (lane_done_q[g]),
            .pass_i     (pass_q),
            .want_step  (want_step[g]),
            .reach_goal (reach_goal[g])
        );
    end

    wl_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_SETTLE),
        .expired (settle_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start) state_d = ST_SAMPLE_REQ;
            ST_SAMPLE_REQ:  state_d = ST_SAMPLE_WAIT;
            ST_SAMPLE_WAIT: if (smp_vld)
                                state_d = (idx_q == LAST_SMP) ? ST_JUDGE : ST_SAMPLE_REQ;
            ST_JUDGE:       if (|want_step)
                                state_d = ST_STEP;
                            else if (pass_q == PASS_DOWN)
                                state_d = ST_SAMPLE_REQ;
                            else
                                state_d = ST_IDLE;
            ST_STEP:        if (step_ack)
                                state_d = step_err ? ST_IDLE : ST_SETTLE;
            ST_SETTLE:      if (settle_done) state_d = ST_SAMPLE_REQ;
            default:        state_d = ST_IDLE;
        endcase
    end

    // Search bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q      <= PASS_DOWN;
            lane_done_q <= '0;
            step_mask_q <= '0;
            idx_q       <= '0;
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    pass_q      <= PASS_DOWN;
                    lane_done_q <= '0;
                    idx_q       <= '0;
                    done_q      <= 1'b0;
                    fail_q      <= 1'b0;
                end
                ST_SAMPLE_WAIT: if (smp_vld)
                    idx_q <= (idx_q == LAST_SMP) ? '0 : idx_q + 1'b1;
                ST_JUDGE: begin
                    if (|want_step) begin
                        step_mask_q <= want_step;
                        lane_done_q <= lane_done_q | reach_goal;
                    end else if (pass_q == PASS_DOWN) begin
                        pass_q      <= PASS_UP;
                        lane_done_q <= '0;
                    end else begin
                        done_q      <= 1'b1;
                    end
                end
                ST_STEP: if (step_ack && step_err)
                    fail_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        smp_req    = (state_q == ST_SAMPLE_REQ);
        step_req   = (state_q == ST_STEP);
        step_up    = (pass_q == PASS_UP);
        step_lanes = step_mask_q;
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        fail       = fail_q;
    end

    a_r2_single_cycle_request: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |=> !smp_req);

    a_r6_skip_finished: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> (step_lanes & lane_done_q) == '0);

    a_r6_nonempty_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> step_lanes != '0);

    a_r11_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
        step_req && !step_ack |=> step_req && $stable(step_lanes) && $stable(step_up));

    a_r8_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
        step_req && step_ack && step_err |=> fail && !busy && !done);

    a_r7_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    a_r4_down_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !step_up && !done && !fail);

endmodule

// File: tb/sim_wl_edge_search.sv
module sim_wl_edge_search;

    localparam int L    = 8;
    localparam int NS   = 5;
    localparam int SET  = 4;
    localparam int MAXC = 63;
    localparam int LAT  = 2;

    typedef struct packed {
        logic [1:0]   kind;   // 0 step, 1 done, 2 fail
        logic         up;
        logic [L-1:0] mask;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         smp_req, smp_vld = 1'b0;
    logic [L-1:0] smp_bits = '0;
    logic         step_req, step_up;
    logic [L-1:0] step_lanes;
    logic         step_ack = 1'b0, step_err = 1'b0;
    logic         busy, done, fail;

    wl_edge_search #(.LANES(L), .SAMPLES(NS), .SETTLE_CYC(SET)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .smp_req(smp_req), .smp_vld(smp_vld), .smp_bits(smp_bits),
        .step_req(step_req), .step_up(step_up), .step_lanes(step_lanes),
        .step_ack(step_ack), .step_err(step_err),
        .busy(busy), .done(done), .fail(fail)
    );

    always #4 clk = ~clk;

    int    checks = 0, errors = 0, cyc = 0;
    item_t q[$];
    int    code_m[L], edge_m[L], jit_m[L], exp_final[L];
    int    sidx = 0;
    bit    pend = 0, gap_on = 0, prev_busy = 0;
    int    gap = 0, lat_cnt = 0;
    logic [L-1:0] mask_seen;
    logic         up_seen;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit hi(input int code, input int edg, input int jit, input int s);
        return (code >= edg) || ((code >= edg - jit) && (s % 2 == 1));
    endfunction

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver side of the scoreboard: predict every step and the outcome
    task automatic gen_expect();
        int c[L];
        int cnt;
        bit pass_up = 0;
        logic [L-1:0] dn = '0, nd, mask;
        bit err;
        foreach (c[l]) c[l] = code_m[l];
        for (int it = 0; it < 4000; it++) begin
            mask = '0;
            nd   = dn;
            for (int l = 0; l < L; l++) begin
                cnt = 0;
                for (int s = 0; s < NS; s++) cnt += hi(c[l], edge_m[l], jit_m[l], s);
                if (!dn[l]) begin
                    if (pass_up ? (cnt == NS) : (cnt == 0)) nd[l] = 1'b1;
                    else mask[l] = 1'b1;
                end
            end
            if (mask == '0) begin
                if (!pass_up) begin
                    pass_up = 1;
                    dn = '0;
                    continue;
                end
                q.push_back('{kind: 2'd1, up: 1'b0, mask: '0});
                foreach (c[l]) exp_final[l] = c[l];
                return;
            end
            q.push_back('{kind: 2'd0, up: pass_up, mask: mask});
            dn = nd;
            err = 0;
            for (int l = 0; l < L; l++)
                if (mask[l] && ((!pass_up && c[l] == 0) || (pass_up && c[l] == MAXC))) err = 1;
            if (err) begin
                q.push_back('{kind: 2'd2, up: 1'b0, mask: '0});
                return;
            end
            for (int l = 0; l < L; l++)
                if (mask[l]) c[l] += pass_up ? 1 : -1;
        end
    endtask

    // Models of the stepper and the sample source, plus the monitor
    always @(negedge clk) begin
        bit had_pend;
        item_t it;
        bit err;
        if (rst_n) begin
            // stepper
            if (step_ack) begin
                if (!step_err) begin gap_on = 1; gap = 0; end
                step_ack = 1'b0;
                step_err = 1'b0;
            end else if (step_req) begin
                if (lat_cnt == 0) begin
                    mask_seen = step_lanes;
                    up_seen   = step_up;
                end else begin
                    chk(step_lanes == mask_seen && step_up == up_seen,
                        "R11 step request held stable", int'(step_lanes), int'(mask_seen));
                end
                lat_cnt++;
                if (lat_cnt == LAT) begin
                    lat_cnt = 0;
                    chk(sidx % NS == 0, "R2 whole rounds before a step", sidx % NS, 0);
                    if (q.size() == 0) begin
                        chk(0, "R6 unexpected step request", int'(step_lanes), 0);
                    end else begin
                        it = q.pop_front();
                        chk(it.kind == 2'd0, "R7 step where search should end", 0, int'(it.kind));
                        chk(step_up == it.up, step_up ? "R5 step direction" : "R4 step direction",
                            int'(step_up), int'(it.up));
                        chk(step_lanes == it.mask, it.up ? "R3 R5 R6 up-pass mask" : "R3 R4 R6 down-pass mask",
                            int'(step_lanes), int'(it.mask));
                    end
                    err = 0;
                    for (int l = 0; l < L; l++)
                        if (step_lanes[l] && ((!step_up && code_m[l] == 0) || (step_up && code_m[l] == MAXC)))
                            err = 1;
                    if (!err)
                        for (int l = 0; l < L; l++)
                            if (step_lanes[l]) code_m[l] += step_up ? 1 : -1;
                    step_ack = 1'b1;
                    step_err = err;
                end
            end
            // sample source
            had_pend = pend;
            if (pend) begin
                for (int l = 0; l < L; l++) smp_bits[l] = hi(code_m[l], edge_m[l], jit_m[l], sidx % NS);
                smp_vld = 1'b1;
                sidx++;
                pend = 0;
            end else begin
                smp_vld = 1'b0;
            end
            if (gap_on) begin
                if (smp_req) begin
                    chk(gap == SET, "R9 settle gap", gap, SET);
                    gap_on = 0;
                end else begin
                    gap++;
                end
            end
            if (smp_req) begin
                if (had_pend) chk(0, "R2 request while sample outstanding", 1, 0);
                pend = 1;
            end
            // outcome monitor
            if (prev_busy && !busy) begin
                if (q.size() == 0) begin
                    chk(0, "R7 search ended with nothing expected", int'(done), 0);
                end else begin
                    it = q.pop_front();
                    if (it.kind == 2'd1) begin
                        chk(done && !fail, "R7 done status", int'({done, fail}), 2);
                        for (int l = 0; l < L; l++)
                            chk(code_m[l] == exp_final[l], "R7 final lane code", code_m[l], exp_final[l]);
                    end else begin
                        chk(it.kind == 2'd2 && fail && !done, "R8 fail status", int'({done, fail}), 1);
                    end
                end
            end
            prev_busy = busy;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            summary_and_end();
        end
    end

    task automatic run_case(input bit stray);
        int n = 0;
        sidx = 0;
        q.delete();
        gen_expect();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (busy) begin
            @(negedge clk);
            n++;
            if (stray && n == 40) start = 1'b1;     // R10: pulse while busy
            if (stray && n == 41) start = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R10 R7 all expected items consumed", q.size(), 0);
        chk(!busy, "R10 stays idle after search", int'(busy), 0);
    endtask

    initial begin
        int ia[L], ea[L], ja[L];
        repeat (4) @(negedge clk);
        // R1: state during and after reset
        chk(!busy && !smp_req && !step_req, "R1 idle in reset", int'({busy, smp_req, step_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fail && !smp_req && !step_req, "R1 idle after reset",
            int'({busy, done, fail, smp_req, step_req}), 0);

        // Mixed lanes with jitter bands and a stray start
        ia = '{20, 10, 5, 30, 40, 12, 8, 50};
        ea = '{15, 12, 5, 31, 38, 20, 3, 45};
        ja = '{2, 0, 3, 1, 0, 4, 2, 0};
        foreach (ia[l]) begin code_m[l] = ia[l]; edge_m[l] = ea[l]; jit_m[l] = ja[l]; end
        run_case(1'b1);

        // All lanes below their edge: down pass ends at once
        foreach (ia[l]) begin code_m[l] = 2; edge_m[l] = 10 + l; jit_m[l] = 0; end
        run_case(1'b0);

        // Down-step error at code zero (R8)
        foreach (ia[l]) begin code_m[l] = 6; edge_m[l] = 4; jit_m[l] = 0; end
        code_m[3] = 3; edge_m[3] = 0;
        run_case(1'b0);
        chk(fail && !done, "R8 fail held after down error", int'({done, fail}), 1);

        // Up-step error past the top code (R8)
        foreach (ia[l]) begin code_m[l] = 20; edge_m[l] = 22; jit_m[l] = 1; end
        code_m[5] = 58; edge_m[5] = 70;
        run_case(1'b0);
        chk(fail && !done, "R8 fail held after up error", int'({done, fail}), 1);

        // A clean search after a failure clears the status
        foreach (ia[l]) begin code_m[l] = 30 - l; edge_m[l] = 25; jit_m[l] = l % 3; end
        run_case(1'b0);
        chk(done && !fail, "R7 done after recovery", int'({done, fail}), 2);

        summary_and_end();
    end

endmodule